// File: doc/BRIEF.md
# 64-Byte DMA Burst Sequencer

This block moves one 64-byte block between a 64-bit DRAM port and a 32-bit peripheral memory port, in either direction. A one-cycle start pulse, a direction bit, a DRAM byte address and a peripheral byte address launch a transfer. The block performs eight 64-bit DRAM transactions and sixteen 32-bit peripheral transactions. It does not overlap the two ports, so each port waits for its own grant or acknowledge in turn.

On the way to DRAM, two peripheral reads fill one 64-bit beat, which is then written to DRAM. On the way to the peripheral, one DRAM read fills a 64-bit staging word, which is then sent as two peripheral writes. The DRAM address output always shows the beat being serviced, so software can read the progress back. A 4-bit state code shows activity, a one-cycle done pulse marks the end of a transfer, and a sticky flag reports a DRAM grant that took too long.

Top module: `dma_burst_seq`

## Requirements
- R1: When `state_o` is 0, a cycle with `start_i` high starts a transfer. `dir_i` = 0 moves data from the peripheral to DRAM, and `dir_i` = 1 moves data from DRAM to the peripheral.
- R2: A transfer makes exactly eight DRAM transactions. While beat k (0..7) is requested, `dram_addr_o` equals the aligned base plus 8·k. After the transfer it reads base plus 64.
- R3: The low 3 bits of `dram_addr_i` are forced to zero. The low 2 bits of `per_addr_i` are dropped. `per_waddr_o` is a word address and increases by one after every peripheral transaction.
- R4: On the way to DRAM, beat k carries peripheral word 2k (relative to the start word) in bits [63:32] and word 2k+1 in bits [31:0]. The words are read in ascending order, and no DRAM location outside the 64 bytes is written.
- R5: On the way to the peripheral, bits [63:32] of DRAM beat k go to word 2k and bits [31:0] go to word 2k+1. No peripheral word outside the 16 is written.
- R6: A transfer to DRAM takes `per_addr_i` in the start cycle. A transfer to the peripheral takes `per_addr_i` in the cycle of its first DRAM grant.
- R7: `state_o` is nonzero from the cycle after a start until the transfer ends. `done_o` is high for exactly one cycle after the last transaction, and then `state_o` returns to 0.
- R8: `start_i` is ignored while a transfer is in progress. The running transfer's addresses, direction and beat count do not change.
- R9: `overrun_o` is set when a DRAM request goes more than `GNT_LIMIT` (128) consecutive cycles without a grant. It stays set until reset.
- R10: `dram_req_o` and `per_req_o` are never high in the same cycle. A request stays high, with its direction unchanged, until `dram_gnt_i` or `per_ack_i` arrives.
- R11: After reset, `state_o`, `busy_o`, `done_o`, both requests, `overrun_o` and `dram_addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only when idle |
| dir_i | input | 1 | 0: peripheral to DRAM, 1: DRAM to peripheral |
| dram_addr_i | input | DRAM_AW | DRAM byte address of the block |
| per_addr_i | input | PER_BAW | Peripheral byte address of the block |
| busy_o | output | 1 | Transfer active |
| done_o | output | 1 | One-cycle completion pulse |
| state_o | output | 4 | Sequencer state code, 0 when idle |
| dram_addr_o | output | DRAM_AW | Live DRAM byte address of the current beat |
| overrun_o | output | 1 | Sticky grant-wait overrun flag |
| dram_req_o | output | 1 | DRAM transaction request |
| dram_we_o | output | 1 | DRAM request is a write |
| dram_gnt_i | input | 1 | DRAM grant; read data is valid in the same cycle |
| dram_wdata_o | output | 64 | DRAM write data |
| dram_rdata_i | input | 64 | DRAM read data |
| per_req_o | output | 1 | Peripheral transaction request |
| per_we_o | output | 1 | Peripheral request is a write |
| per_ack_i | input | 1 | Peripheral acknowledge; read data is valid in the same cycle |
| per_waddr_o | output | PER_BAW-2 | Peripheral word address |
| per_wdata_o | output | 32 | Peripheral write data |
| per_rdata_i | input | 32 | Peripheral read data |

## Verification
Every cycle, the assertions check that the two ports never request at the same time and that requests are held until granted. They also check that the DRAM address steps by 8 on each beat, that the peripheral word address steps by one, that `done_o` lasts a single cycle, that a start is ignored while busy, and that the overrun flag is sticky and rises only during a stall. Other properties need whole transfers and a memory model, so only the bench scenarios can show them. These are the word packing order in each direction, the late capture of the peripheral address for transfers toward the peripheral, the exact 128/129-cycle threshold of the overrun flag, and the absence of stray writes next to the block.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_PRD_HI = 4'd1,
    ST_PRD_LO = 4'd2,
    ST_DWR    = 4'd3,
    ST_DRD    = 4'd4,
    ST_PWR_HI = 4'd5,
    ST_PWR_LO = 4'd6,
    ST_DONE   = 4'd7
  } seq_state_e;

  typedef enum logic {
    DIR_TO_DRAM = 1'b0,
    DIR_TO_PER  = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int DRAM_AW    = 24,
  parameter int PER_BAW    = 11,
  parameter int PER_DW     = 32,
  parameter int BEATS      = 8,
  parameter int BEAT_BYTES = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic                        take_per_i,
  input  logic                        per_step_i,
  input  logic                        beat_step_i,
  input  logic [DRAM_AW-1:0]          dram_addr_i,
  input  logic [PER_BAW-1:0]          per_addr_i,
  output logic [DRAM_AW-1:0]          dram_addr_o,
  output logic [PER_BAW-$clog2(PER_DW/8)-1:0] per_waddr_o,
  output logic                        first_beat_o,
  output logic                        last_beat_o
);
  localparam int OFF_W   = $clog2(BEAT_BYTES);
  localparam int PER_OFF = $clog2(PER_DW/8);
  localparam int PWA     = PER_BAW - PER_OFF;
  localparam int CNT_W   = $clog2(BEATS);

  logic [DRAM_AW-1:0] dram_q;
  logic [PWA-1:0]     per_q;
  logic [CNT_W-1:0]   beat_q;
  logic               unused_low;

  assign unused_low = ^{dram_addr_i[OFF_W-1:0], per_addr_i[PER_OFF-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dram_q <= '0;
      beat_q <= '0;
    end else if (load_i) begin
      dram_q <= {dram_addr_i[DRAM_AW-1:OFF_W], {OFF_W{1'b0}}};
      beat_q <= '0;
    end else if (beat_step_i) begin
      dram_q <= dram_q + DRAM_AW'(BEAT_BYTES);
      beat_q <= beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          per_q <= '0;
    else if (take_per_i)  per_q <= per_addr_i[PER_BAW-1:PER_OFF];
    else if (per_step_i)  per_q <= per_q + 1'b1;
  end

  assign dram_addr_o  = dram_q;
  assign per_waddr_o  = per_q;
  assign first_beat_o = (beat_q == '0);
  assign last_beat_o  = (beat_q == CNT_W'(BEATS-1));

  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_step_i && !load_i) |=> (dram_addr_o == $past(dram_addr_o) + DRAM_AW'(BEAT_BYTES))); // R2
  AST_PER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_step_i && !take_per_i) |=> (per_waddr_o == $past(per_waddr_o) + 1'b1)); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!beat_step_i && !load_i) |=> $stable(dram_addr_o)); // R2
endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
  parameter int PER_DW = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_hi_i,
  input  logic                  cap_lo_i,
  input  logic                  cap_beat_i,
  input  logic                  sel_lo_i,
  input  logic [PER_DW-1:0]     per_rdata_i,
  input  logic [2*PER_DW-1:0]   dram_rdata_i,
  output logic [2*PER_DW-1:0]   dram_wdata_o,
  output logic [PER_DW-1:0]     per_wdata_o
);
  localparam int DRAM_DW = 2 * PER_DW;

  logic [PER_DW-1:0] half_q [2];

  // half 1 = upper (first) word, half 0 = lower (second) word
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic cap_word;
    assign cap_word = (h == 1) ? cap_hi_i : cap_lo_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         half_q[h] <= '0;
      else if (cap_beat_i) half_q[h] <= dram_rdata_i[h*PER_DW +: PER_DW];
      else if (cap_word)   half_q[h] <= per_rdata_i;
    end
  end

  assign dram_wdata_o = {half_q[1], half_q[0]};
  assign per_wdata_o  = sel_lo_i ? half_q[0] : half_q[1];

  AST_CAP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cap_hi_i, cap_lo_i, cap_beat_i}) <= 1); // R4
  AST_BEAT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_beat_i |=> (dram_wdata_o == $past(dram_rdata_i))); // R5
endmodule

// File: rtl/dma_gnt_wdog.sv
module dma_gnt_wdog #(
  parameter int GNT_LIMIT = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic gnt_i,
  output logic overrun_o
);
  localparam int CW = $clog2(GNT_LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else if (wait_i && !gnt_i) begin
      if (cnt_q == CW'(GNT_LIMIT)) ovr_q <= 1'b1;
      else                         cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign overrun_o = ovr_q;

  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R9
  AST_OVR_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(wait_i && !gnt_i)); // R9
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(GNT_LIMIT)); // R9
endmodule

// File: rtl/dma_burst_fsm.sv
module dma_burst_fsm
  import dma_burst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       dir_i,
  input  logic       dram_gnt_i,
  input  logic       per_ack_i,
  input  logic       last_beat_i,
  output seq_state_e state_o,
  output logic       start_acc_o,
  output logic       dram_req_o,
  output logic       dram_we_o,
  output logic       per_req_o,
  output logic       per_we_o,
  output logic       per_lo_o,
  output logic       dram_fire_o,
  output logic       per_fire_o,
  output logic       beat_step_o,
  output logic       done_o
);
  seq_state_e st_q, st_d;

  assign dram_req_o  = (st_q == ST_DWR) || (st_q == ST_DRD);
  assign dram_we_o   = (st_q == ST_DWR);
  assign per_req_o   = (st_q == ST_PRD_HI) || (st_q == ST_PRD_LO) ||
                       (st_q == ST_PWR_HI) || (st_q == ST_PWR_LO);
  assign per_we_o    = (st_q == ST_PWR_HI) || (st_q == ST_PWR_LO);
  assign per_lo_o    = (st_q == ST_PRD_LO) || (st_q == ST_PWR_LO);
  assign dram_fire_o = dram_req_o && dram_gnt_i;
  assign per_fire_o  = per_req_o && per_ack_i;
  assign start_acc_o = (st_q == ST_IDLE) && start_i;
  assign beat_step_o = ((st_q == ST_DWR) && dram_gnt_i) || ((st_q == ST_PWR_LO) && per_ack_i);
  assign done_o      = (st_q == ST_DONE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = (xfer_dir_e'(dir_i) == DIR_TO_PER) ? ST_DRD : ST_PRD_HI;
      ST_PRD_HI: if (per_ack_i) st_d = ST_PRD_LO;
      ST_PRD_LO: if (per_ack_i) st_d = ST_DWR;
      ST_DWR:    if (dram_gnt_i) st_d = last_beat_i ? ST_DONE : ST_PRD_HI;
      ST_DRD:    if (dram_gnt_i) st_d = ST_PWR_HI;
      ST_PWR_HI: if (per_ack_i) st_d = ST_PWR_LO;
      ST_PWR_LO: if (per_ack_i) st_d = last_beat_i ? ST_DONE : ST_DRD;
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dram_req_o && per_req_o)); // R10
  AST_DRAM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_req_o && !dram_gnt_i) |=> (dram_req_o && $stable(dram_we_o))); // R10
  AST_PER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_req_o && !per_ack_i) |=> (per_req_o && $stable(per_we_o) && $stable(per_lo_o))); // R10
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && state_o == ST_IDLE)); // R7
  AST_START_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && start_i) |=> (state_o != ST_IDLE)); // R1
  AST_BUSY_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_IDLE && state_o != ST_DONE && !dram_gnt_i && !per_ack_i) |=>
      $stable(state_o)); // R8
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_burst_pkg::*;
#(
  parameter int DRAM_AW   = 24,
  parameter int PER_BAW   = 11,
  parameter int PER_DW    = 32,
  parameter int BEATS     = 8,
  parameter int GNT_LIMIT = 128
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      dir_i,
  input  logic [DRAM_AW-1:0]        dram_addr_i,
  input  logic [PER_BAW-1:0]        per_addr_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [3:0]                state_o,
  output logic [DRAM_AW-1:0]        dram_addr_o,
  output logic                      overrun_o,
  output logic                      dram_req_o,
  output logic                      dram_we_o,
  input  logic                      dram_gnt_i,
  output logic [2*PER_DW-1:0]       dram_wdata_o,
  input  logic [2*PER_DW-1:0]       dram_rdata_i,
  output logic                      per_req_o,
  output logic                      per_we_o,
  input  logic                      per_ack_i,
  output logic [PER_BAW-$clog2(PER_DW/8)-1:0] per_waddr_o,
  output logic [PER_DW-1:0]         per_wdata_o,
  input  logic [PER_DW-1:0]         per_rdata_i
);
  localparam int DRAM_DW    = 2 * PER_DW;
  localparam int BEAT_BYTES = DRAM_DW / 8;

  seq_state_e st;
  logic start_acc, per_lo, dram_fire, per_fire, beat_step;
  logic first_beat, last_beat, take_per;

  dma_burst_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .dir_i       (dir_i),
    .dram_gnt_i  (dram_gnt_i),
    .per_ack_i   (per_ack_i),
    .last_beat_i (last_beat),
    .state_o     (st),
    .start_acc_o (start_acc),
    .dram_req_o  (dram_req_o),
    .dram_we_o   (dram_we_o),
    .per_req_o   (per_req_o),
    .per_we_o    (per_we_o),
    .per_lo_o    (per_lo),
    .dram_fire_o (dram_fire),
    .per_fire_o  (per_fire),
    .beat_step_o (beat_step),
    .done_o      (done_o)
  );

  // to DRAM: take peripheral address at start; to peripheral: at first DRAM grant
  assign take_per = (start_acc && (xfer_dir_e'(dir_i) == DIR_TO_DRAM)) ||
                    (dram_fire && !dram_we_o && first_beat);

  dma_addr_gen #(
    .DRAM_AW    (DRAM_AW),
    .PER_BAW    (PER_BAW),
    .PER_DW     (PER_DW),
    .BEATS      (BEATS),
    .BEAT_BYTES (BEAT_BYTES)
  ) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start_acc),
    .take_per_i   (take_per),
    .per_step_i   (per_fire),
    .beat_step_i  (beat_step),
    .dram_addr_i  (dram_addr_i),
    .per_addr_i   (per_addr_i),
    .dram_addr_o  (dram_addr_o),
    .per_waddr_o  (per_waddr_o),
    .first_beat_o (first_beat),
    .last_beat_o  (last_beat)
  );

  dma_stage_buf #(
    .PER_DW (PER_DW)
  ) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_hi_i     (per_fire && !per_we_o && !per_lo),
    .cap_lo_i     (per_fire && !per_we_o && per_lo),
    .cap_beat_i   (dram_fire && !dram_we_o),
    .sel_lo_i     (per_lo),
    .per_rdata_i  (per_rdata_i),
    .dram_rdata_i (dram_rdata_i),
    .dram_wdata_o (dram_wdata_o),
    .per_wdata_o  (per_wdata_o)
  );

  dma_gnt_wdog #(
    .GNT_LIMIT (GNT_LIMIT)
  ) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wait_i    (dram_req_o),
    .gnt_i     (dram_gnt_i),
    .overrun_o (overrun_o)
  );

  assign state_o = st;
  assign busy_o  = (st != ST_IDLE);

  AST_BUSY_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc |=> (busy_o && state_o != 4'd0)); // R7
endmodule

// File: tb/dma_burst_seq_tb_top.sv
`timescale 1ns/1ps
module dma_burst_seq_tb_top;
  localparam int DRAM_AW = 24;
  localparam int PER_BAW = 11;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic start_i, dir_i;
  logic [DRAM_AW-1:0] dram_addr_i;
  logic [PER_BAW-1:0] per_addr_i;
  logic busy_o, done_o, overrun_o;
  logic [3:0] state_o;
  logic [DRAM_AW-1:0] dram_addr_o;
  logic dram_req_o, dram_we_o, dram_gnt_i;
  logic [63:0] dram_wdata_o, dram_rdata_i;
  logic per_req_o, per_we_o, per_ack_i;
  logic [PER_BAW-3:0] per_waddr_o;
  logic [31:0] per_wdata_o, per_rdata_i;

  always #10 clk_i = ~clk_i;

  dma_burst_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dir_i(dir_i),
    .dram_addr_i(dram_addr_i), .per_addr_i(per_addr_i),
    .busy_o(busy_o), .done_o(done_o), .state_o(state_o),
    .dram_addr_o(dram_addr_o), .overrun_o(overrun_o),
    .dram_req_o(dram_req_o), .dram_we_o(dram_we_o), .dram_gnt_i(dram_gnt_i),
    .dram_wdata_o(dram_wdata_o), .dram_rdata_i(dram_rdata_i),
    .per_req_o(per_req_o), .per_we_o(per_we_o), .per_ack_i(per_ack_i),
    .per_waddr_o(per_waddr_o), .per_wdata_o(per_wdata_o), .per_rdata_i(per_rdata_i)
  );

  int n_checks = 0;
  int n_errors = 0;
  logic [63:0] dmem [512];
  logic [31:0] pmem [512];
  int gdelay, pdelay, dwait, pwait;
  int beats, pxs, addr_err, perr, conflicts;
  logic [DRAM_AW-1:0] exp_dbase;
  int exp_pbase;

  function automatic logic [31:0] pw(int i);
    return 32'h1000_0000 + 32'(i) * 32'h0001_0001;
  endfunction
  function automatic logic [63:0] dw(int i);
    return {32'hD000_0000 + 32'(i), 32'hE000_0000 + 32'(i) * 32'd3};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory models, acting at the falling edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (dram_req_o && per_req_o) conflicts++;
      if (dram_gnt_i) begin
        dram_gnt_i = 1'b0; dwait = 0;
      end else if (dram_req_o) begin
        if (dwait == gdelay) begin
          dram_gnt_i = 1'b1;
          if (dram_addr_o != exp_dbase + DRAM_AW'(beats * 8)) addr_err++;
          beats++;
          if (dram_we_o) dmem[dram_addr_o[11:3]] = dram_wdata_o;
          else dram_rdata_i = dmem[dram_addr_o[11:3]];
        end else dwait++;
      end
      if (per_ack_i) begin
        per_ack_i = 1'b0; pwait = 0;
      end else if (per_req_o) begin
        if (pwait == pdelay) begin
          per_ack_i = 1'b1;
          if (int'(per_waddr_o) != exp_pbase + pxs) perr++;
          pxs++;
          if (per_we_o) pmem[per_waddr_o] = per_wdata_o;
          else per_rdata_i = pmem[per_waddr_o];
        end else pwait++;
      end
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    dram_gnt_i = 1'b0; per_ack_i = 1'b0; dwait = 0; pwait = 0;
    repeat (3) @(negedge clk_i);
    chk(state_o == 4'd0 && !busy_o && !done_o, "R11 idle", state_o, 0);
    chk(!dram_req_o && !per_req_o && !overrun_o && dram_addr_o == '0, "R11 outputs",
        {dram_req_o, per_req_o, overrun_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic run(input bit dir, input logic [23:0] da, input logic [10:0] pa,
                     input logic [10:0] pa_late, input int gd, input int pd, input bit poke);
    int to, zstate, bad, di;
    bit seen;
    for (int i = 0; i < 512; i++) begin dmem[i] = dw(i); pmem[i] = pw(i); end
    gdelay = gd; pdelay = pd;
    beats = 0; pxs = 0; addr_err = 0; perr = 0; conflicts = 0; zstate = 0;
    exp_dbase = {da[23:3], 3'b000};
    exp_pbase = dir ? int'(pa_late[10:2]) : int'(pa[10:2]);
    di = int'(exp_dbase[11:3]);
    @(negedge clk_i);
    start_i = 1'b1; dir_i = dir; dram_addr_i = da; per_addr_i = pa;
    @(negedge clk_i);
    start_i = 1'b0; per_addr_i = pa_late;
    seen = 0; to = 0;
    while (!seen && to < 40000) begin
      if (done_o) seen = 1;
      else begin
        if (state_o == 4'd0) zstate++;
        if (poke && to == 6) begin
          start_i = 1'b1; dir_i = ~dir; dram_addr_i = 24'h0001F0;
        end else start_i = 1'b0;
        @(negedge clk_i);
        to++;
      end
    end
    start_i = 1'b0;
    chk(seen, "R7 done pulse", seen, 1);
    @(negedge clk_i);
    chk(!done_o && state_o == 4'd0 && !busy_o, "R7 single pulse", {done_o, state_o}, 0);
    chk(zstate == 0, "R7 state nonzero while active", zstate, 0);
    chk(beats == 8, "R2 beat count", beats, 8);
    chk(addr_err == 0, "R2 live address", addr_err, 0);
    chk(dram_addr_o == exp_dbase + 24'd64, "R2 end address", dram_addr_o, exp_dbase + 24'd64);
    chk(pxs == 16, "R3 word count", pxs, 16);
    chk(perr == 0, "R6 peripheral address", perr, 0);
    chk(conflicts == 0, "R10 port exclusion", conflicts, 0);
    bad = 0;
    if (!dir) begin
      for (int k = 0; k < 8; k++)
        if (dmem[di + k] != {pw(exp_pbase + 2*k), pw(exp_pbase + 2*k + 1)}) bad++;
      if (dmem[di + 8] != dw(di + 8)) bad++;
      if (di > 0 && dmem[di - 1] != dw(di - 1)) bad++;
      chk(bad == 0, "R4 packing to DRAM", bad, 0);
    end else begin
      for (int k = 0; k < 8; k++) begin
        if (pmem[exp_pbase + 2*k] != dw(di + k)[63:32]) bad++;
        if (pmem[exp_pbase + 2*k + 1] != dw(di + k)[31:0]) bad++;
      end
      if (pmem[exp_pbase + 16] != pw(exp_pbase + 16)) bad++;
      if (exp_pbase > 0 && pmem[exp_pbase - 1] != pw(exp_pbase - 1)) bad++;
      chk(bad == 0, "R5 split to peripheral", bad, 0);
    end
  endtask

  initial begin
    logic [23:0] da;
    logic [10:0] pa, pl;
    start_i = 0; dir_i = 0; dram_addr_i = '0; per_addr_i = '0;
    dram_rdata_i = '0; per_rdata_i = '0; gdelay = 0; pdelay = 0; exp_dbase = '0; exp_pbase = 0;
    do_reset();
    // R1 sweep: both directions, unaligned addresses (R3), late address changes (R6)
    for (int d = 0; d < 2; d++) begin
      for (int a = 0; a < 3; a++) begin
        for (int t = 0; t < 3; t++) begin
          case (a)
            0: begin da = 24'h000040; pa = 11'h000; end
            1: begin da = 24'h000105; pa = 11'h07D; end
            default: begin da = 24'h000E38; pa = 11'h5F0; end
          endcase
          pl = (t == 0) ? pa : pa + 11'h100;
          run(d[0], da, pa, pl, (t == 2) ? 1 : t * 3, (t == 1) ? 1 : t * 2, 1'b0);
        end
      end
    end
    // R8: start pulsed mid-transfer is ignored
    run(1'b0, 24'h000200, 11'h040, 11'h300, 1, 2, 1'b1);
    chk(!overrun_o, "R9 no overrun at short waits", overrun_o, 0);
    // R9 threshold
    run(1'b0, 24'h000080, 11'h020, 11'h020, 128, 0, 1'b0);
    chk(!overrun_o, "R9 128 stalls tolerated", overrun_o, 0);
    run(1'b1, 24'h000080, 11'h020, 11'h020, 129, 0, 1'b0);
    chk(overrun_o, "R9 129 stalls flagged", overrun_o, 1);
    run(1'b0, 24'h000300, 11'h100, 11'h100, 0, 0, 1'b0);
    chk(overrun_o, "R9 flag sticky", overrun_o, 1);
    do_reset();
    chk(!overrun_o, "R9 cleared by reset", overrun_o, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule